// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in the translation cache. It reads one or two 32-bit descriptors from memory and returns either a fill entry or a fault code. The fill entry holds the page number, the page size, the permission bits, the domain, the global and execute-never flags and a packed attribute word. Requests enter through a valid/ready handshake and wait in a small queue. The walker serves them strictly in arrival order, and only one walk is in progress at a time.

A split width picks which of two table base registers to use. The walk then issues a first-level read. That descriptor is either a fault, a 1MB section, or a pointer to a second-level table. A second-level descriptor maps a 64KB page or a 4KB page, or it is invalid. The enable bits are read as static configuration. The MMU enable gates the start of a walk. The cache enable controls the uncacheable flag on first-level reads. The access-flag enable turns on the access-flag check.

Top module: `ptw_walker`

## Requirements
- R1: With split width N (`cfgSplit`), base 0 is used when N is 0 or when VA[31:32-N] is all zero. Otherwise base 1 is used and N is taken as 0. The first-level read address is base[31:14-N] with VA[31-N:20] placed at bit 2 upward, and bits [1:0] are zero.
- R2: Descriptor type is in bits [1:0]: 00 fault, 01 table, 10 section, 11 reserved. A first-level fault or reserved type ends the walk with `faultCode` 1. `faultFetch` copies the request's fetch flag, and `faultWrite` copies its write flag.
- R3: A section descriptor yields a fill with `fillShift` 20 and `fillPfn` = desc[31:20]. It also gives `fillVpn` = VA>>20, domain desc[8:5], `fillAp` = {desc[15], desc[11:10]}, `fillXn` = desc[4] and `fillGlobal` = !desc[17]. The request's ASID is carried to `fillAsid`.
- R4: A table descriptor causes a second read at {desc[31:10], VA[19:12], 2'b00}.
- R5: A second-level descriptor with type 00 gives `faultCode` 2. Type 01 maps 64KB: shift 16, pfn desc[31:16], xn desc[15], tex desc[14:12]. Type 1x maps 4KB: shift 12, pfn desc[31:12], xn desc[0], tex desc[8:6]. Both page kinds use AP {desc[9], desc[5:4]}, shareable desc[10] and global !desc[11]. Their domain comes from the first-level desc[8:5].
- R6: With `cfgAfEn` set, AP bit 0 equal to 0 on a section gives `faultCode` 3, and on a second-level page gives `faultCode` 4.
- R7: First-level reads drive `memReqUncached` = !`cfgCacheOn`. Second-level reads never set it. A read request holds its address until it is accepted.
- R8: Requests are queued in order. `reqReady` is low when the queue is full, and each walk starts only after the previous one has produced its result.
- R9: `fillAttr` is an 11-bit word with not-outer-shareable (always 1) at bit 10, shareable at bit 7, inner at [6:4] and outer at [3:2], and zero elsewhere. The fields come from texcb = {tex, C=desc[3], B=desc[2]}, and s is the descriptor's shareable bit:
  - 0: shareable 1, inner 1, outer 0
  - 1: shareable 1, inner 3, outer 0
  - 2: shareable s, inner 6, outer 2
  - 3: shareable s, inner 7, outer 3
  - 4: shareable s, inner 0, outer 0
  - 7: shareable s, inner 5, outer 1
  - 8: shareable 0, inner 3, outer 0
  - 16 to 31: shareable s, inner texcb[1:0], outer texcb[3:2]
  - all other values: encoded as for 0.
- R10: A section with bit 18 set gives `faultCode` 1. The access-flag check takes priority over it.
- R11: While `cfgMmuOn` is low, no walk starts and queued requests wait.
- R12: Each request produces exactly one one-cycle pulse, on either `fillValid` or `faultValid`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Walk request valid |
| reqReady | output | 1 | Queue can accept |
| reqVa | input | 32 | Virtual address |
| reqFetch | input | 1 | Instruction fetch |
| reqWrite | input | 1 | Write access |
| reqAsid | input | ASID_W | Address-space ID |
| cfgBase0 | input | 32 | Table base 0 |
| cfgBase1 | input | 32 | Table base 1 |
| cfgSplit | input | 3 | Split width N |
| cfgMmuOn | input | 1 | MMU enable |
| cfgCacheOn | input | 1 | Cache enable |
| cfgAfEn | input | 1 | Access-flag check enable |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Read accepted |
| memReqAddr | output | 32 | Descriptor address |
| memReqUncached | output | 1 | Read is uncacheable |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Descriptor word |
| fillValid | output | 1 | Fill entry pulse |
| fillVpn | output | 20 | Virtual page number |
| fillPfn | output | 20 | Physical page number |
| fillShift | output | 5 | Page size shift |
| fillAp | output | 3 | Access permissions |
| fillDomain | output | 4 | Domain |
| fillGlobal | output | 1 | Global mapping |
| fillXn | output | 1 | Execute never |
| fillAsid | output | ASID_W | Request ASID |
| fillAttr | output | 11 | Attribute word |
| faultValid | output | 1 | Fault pulse |
| faultCode | output | 3 | 1 L1 xlate, 2 L2 xlate, 3 L1 access, 4 L2 access |
| faultFetch | output | 1 | Fault was for a fetch |
| faultWrite | output | 1 | Fault was for a write |

## Verification
The bench builds the walker with a queue depth of 2 and an 8-bit ASID. The shallow queue lets two requests, parked while the MMU is off, fill it and drop `reqReady`. The same requests then check in-order draining once walks are allowed. With the default split logic, split widths 0 and 2 reach both base registers and the narrowed index mask. Section, large-page and small-page descriptors run through every fault code and several attribute encodings.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int DESC_W = 32;
  localparam int ATTR_W = 11;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_L1_XLATE  = 3'd1,
    FLT_L2_XLATE  = 3'd2,
    FLT_L1_ACCESS = 3'd3,
    FLT_L2_ACCESS = 3'd4
  } faultKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WAIT1, ST_EVAL1, ST_RD2, ST_WAIT2, ST_EVAL2
  } walkState_e;

  typedef struct packed {
    logic load;
    logic takeL1;
    logic takeL2;
    logic atL2;
    logic emit;
  } walkStrobe_t;

  // Attribute word from the 5-bit tex/C/B code and the shareable bit.
  function automatic logic [ATTR_W-1:0] packAttr(input logic [4:0] texcb, input logic shr);
    logic sh;
    logic [2:0] inr;
    logic [1:0] outr;
    sh = 1'b1; inr = 3'd1; outr = 2'd0;
    if (texcb[4]) begin
      sh = shr; inr = {1'b0, texcb[1:0]}; outr = texcb[3:2];
    end else begin
      case (texcb[3:0])
        4'd1: begin sh = 1'b1; inr = 3'd3; outr = 2'd0; end
        4'd2: begin sh = shr;  inr = 3'd6; outr = 2'd2; end
        4'd3: begin sh = shr;  inr = 3'd7; outr = 2'd3; end
        4'd4: begin sh = shr;  inr = 3'd0; outr = 2'd0; end
        4'd7: begin sh = shr;  inr = 3'd5; outr = 2'd1; end
        4'd8: begin sh = 1'b0; inr = 3'd3; outr = 2'd0; end
        default: begin sh = 1'b1; inr = 3'd1; outr = 2'd0; end
      endcase
    end
    return {1'b1, 2'b00, sh, inr, outr, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_reqq.sv
module ptw_reqq #(
  parameter int WIDTH = 42,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLCNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign notEmpty = (count != '0);
  assign full     = (count == FULLCNT);
  assign headData = slots[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        slots[wrPtr] <= pushData;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R8: the queue never takes an entry it has no room for
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < FULLCNT));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        qNotEmpty,
  input  logic        mmuOn,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        l1IsTable,
  output logic        pop,
  output logic        memReqValid,
  output walkStrobe_t strb
);
  walkState_e state, stateNxt;

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && qNotEmpty && mmuOn;
    strb.takeL1 = (state == ST_WAIT1) && memRspValid;
    strb.takeL2 = (state == ST_WAIT2) && memRspValid;
    strb.atL2   = (state == ST_RD2) || (state == ST_WAIT2) || (state == ST_EVAL2);
    strb.emit   = ((state == ST_EVAL1) && !l1IsTable) || (state == ST_EVAL2);
    pop         = strb.load;
    memReqValid = (state == ST_RD1) || (state == ST_RD2);
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (strb.load) stateNxt = ST_RD1;
      ST_RD1:   if (memReqReady) stateNxt = ST_WAIT1;
      ST_WAIT1: if (memRspValid) stateNxt = ST_EVAL1;
      ST_EVAL1: stateNxt = l1IsTable ? ST_RD2 : ST_IDLE;
      ST_RD2:   if (memReqReady) stateNxt = ST_WAIT2;
      ST_WAIT2: if (memRspValid) stateNxt = ST_EVAL2;
      ST_EVAL2: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R11: an idle walker stays idle while translation is disabled
  p_mmu_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !mmuOn) |=> (state == ST_IDLE));
  // R8: a new walk is only taken from the idle state
  p_one_walk_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> (state == ST_RD1));
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          strb,
  input  logic [VA_W-1:0]      ldVa,
  input  logic                 ldFetch,
  input  logic                 ldWrite,
  input  logic [ASID_W-1:0]    ldAsid,
  input  logic [VA_W-1:0]      cfgBase0,
  input  logic [VA_W-1:0]      cfgBase1,
  input  logic [2:0]           cfgSplit,
  input  logic                 cfgCacheOn,
  input  logic                 cfgAfEn,
  input  logic [DESC_W-1:0]    rspData,
  output logic                 l1IsTable,
  output logic [VA_W-1:0]      memAddr,
  output logic                 memUncached,
  output logic                 fillValid,
  output logic [19:0]          fillVpn,
  output logic [19:0]          fillPfn,
  output logic [4:0]           fillShift,
  output logic [2:0]           fillAp,
  output logic [3:0]           fillDomain,
  output logic                 fillGlobal,
  output logic                 fillXn,
  output logic [ASID_W-1:0]    fillAsid,
  output logic [ATTR_W-1:0]    fillAttr,
  output logic                 faultValid,
  output logic [2:0]           faultCode,
  output logic                 faultFetch,
  output logic                 faultWrite
);
  logic [VA_W-1:0]   va;
  logic              isFetch, isWrite;
  logic [ASID_W-1:0] asid;
  logic [DESC_W-1:0] d1, d2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      va <= '0; isFetch <= 1'b0; isWrite <= 1'b0; asid <= '0;
      d1 <= '0; d2 <= '0;
    end else begin
      if (strb.load) begin
        va <= ldVa; isFetch <= ldFetch; isWrite <= ldWrite; asid <= ldAsid;
      end
      if (strb.takeL1) d1 <= rspData;
      if (strb.takeL2) d2 <= rspData;
    end
  end

  // Table base selection and descriptor addresses
  logic            useBase1;
  logic [2:0]      effSplit;
  logic [VA_W-1:0] baseSel, keepMask, l1Index, l1Addr, l2Addr;

  always_comb begin
    useBase1 = (cfgSplit != 3'd0) && ((va >> (6'd32 - {3'b000, cfgSplit})) != '0);
    effSplit = useBase1 ? 3'd0 : cfgSplit;
    baseSel  = useBase1 ? cfgBase1 : cfgBase0;
    keepMask = ~(32'h0000_3FFF >> effSplit);
    l1Index  = {20'd0, va[31:20]} & (32'h0000_0FFF >> effSplit);
    l1Addr   = (baseSel & keepMask) | (l1Index << 2);
    l2Addr   = {d1[31:10], va[19:12], 2'b00};
  end

  assign memAddr     = strb.atL2 ? l2Addr : l1Addr;
  assign memUncached = !strb.atL2 && !cfgCacheOn;
  assign l1IsTable   = (d1[1:0] == 2'b01);

  // Descriptor decode into a result
  logic        resFault;
  faultKind_e  resCode;
  logic [4:0]  resShift;
  logic [19:0] resPfn;
  logic [2:0]  resAp;
  logic [3:0]  resDom;
  logic        resGlobal, resXn, resShr;
  logic [4:0]  resTexcb;
  logic [VA_W-1:0] vpnFull;

  always_comb begin
    resFault = 1'b0; resCode = FLT_NONE; resShift = 5'd20; resPfn = '0;
    resAp = '0; resDom = d1[8:5]; resGlobal = 1'b0; resXn = 1'b0;
    resShr = 1'b0; resTexcb = '0;
    if (!strb.atL2) begin
      if (d1[1:0] != 2'b10) begin
        resFault = 1'b1; resCode = FLT_L1_XLATE;
      end else if (cfgAfEn && !d1[10]) begin
        resFault = 1'b1; resCode = FLT_L1_ACCESS;
      end else if (d1[18]) begin
        resFault = 1'b1; resCode = FLT_L1_XLATE;
      end else begin
        resShift  = 5'd20;
        resPfn    = {8'd0, d1[31:20]};
        resAp     = {d1[15], d1[11:10]};
        resXn     = d1[4];
        resGlobal = !d1[17];
        resShr    = d1[16];
        resTexcb  = {d1[14:12], d1[3:2]};
      end
    end else begin
      if (d2[1:0] == 2'b00) begin
        resFault = 1'b1; resCode = FLT_L2_XLATE;
      end else if (cfgAfEn && !d2[4]) begin
        resFault = 1'b1; resCode = FLT_L2_ACCESS;
      end else begin
        resAp     = {d2[9], d2[5:4]};
        resGlobal = !d2[11];
        resShr    = d2[10];
        if (d2[1]) begin
          resShift = 5'd12;
          resPfn   = d2[31:12];
          resXn    = d2[0];
          resTexcb = {d2[8:6], d2[3:2]};
        end else begin
          resShift = 5'd16;
          resPfn   = {4'd0, d2[31:16]};
          resXn    = d2[15];
          resTexcb = {d2[14:12], d2[3:2]};
        end
      end
    end
    vpnFull = va >> resShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillValid <= 1'b0; faultValid <= 1'b0;
      fillVpn <= '0; fillPfn <= '0; fillShift <= '0; fillAp <= '0;
      fillDomain <= '0; fillGlobal <= 1'b0; fillXn <= 1'b0; fillAsid <= '0;
      fillAttr <= '0; faultCode <= '0; faultFetch <= 1'b0; faultWrite <= 1'b0;
    end else begin
      fillValid  <= strb.emit && !resFault;
      faultValid <= strb.emit && resFault;
      if (strb.emit) begin
        fillVpn    <= vpnFull[19:0];
        fillPfn    <= resPfn;
        fillShift  <= resShift;
        fillAp     <= resAp;
        fillDomain <= resDom;
        fillGlobal <= resGlobal;
        fillXn     <= resXn;
        fillAsid   <= asid;
        fillAttr   <= packAttr(resTexcb, resShr);
        faultCode  <= resCode;
        faultFetch <= isFetch;
        faultWrite <= isWrite;
      end
    end
  end

  // R12: one outcome per walk, as a single-cycle pulse
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(fillValid && faultValid));
  p_fill_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid || faultValid) |=> !(fillValid || faultValid));
  // R5: only the three page sizes are ever produced
  p_page_size_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (fillShift == 5'd12 || fillShift == 5'd16 || fillShift == 5'd20));
  // R9: reserved attribute bits stay clear, not-outer-shareable is set
  p_attr_shape_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (fillAttr[10] && fillAttr[9:8] == 2'b00 && fillAttr[1:0] == 2'b00));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int ASID_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [31:0]        reqVa,
  input  logic               reqFetch,
  input  logic               reqWrite,
  input  logic [ASID_W-1:0]  reqAsid,
  input  logic [31:0]        cfgBase0,
  input  logic [31:0]        cfgBase1,
  input  logic [2:0]         cfgSplit,
  input  logic               cfgMmuOn,
  input  logic               cfgCacheOn,
  input  logic               cfgAfEn,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [31:0]        memReqAddr,
  output logic               memReqUncached,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  output logic               fillValid,
  output logic [19:0]        fillVpn,
  output logic [19:0]        fillPfn,
  output logic [4:0]         fillShift,
  output logic [2:0]         fillAp,
  output logic [3:0]         fillDomain,
  output logic               fillGlobal,
  output logic               fillXn,
  output logic [ASID_W-1:0]  fillAsid,
  output logic [10:0]        fillAttr,
  output logic               faultValid,
  output logic [2:0]         faultCode,
  output logic               faultFetch,
  output logic               faultWrite
);
  localparam int ENTRY_W = VA_W + 2 + ASID_W;

  logic               qFull, qNotEmpty, qPop, qPush, l1IsTable;
  logic [ENTRY_W-1:0] qHead;
  walkStrobe_t        strb;

  assign reqReady = !qFull;
  assign qPush    = reqValid && reqReady;

  ptw_reqq #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_reqq (
    .clk(clk), .rstN(rstN), .push(qPush),
    .pushData({reqVa, reqFetch, reqWrite, reqAsid}),
    .pop(qPop), .headData(qHead), .notEmpty(qNotEmpty), .full(qFull));

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .qNotEmpty(qNotEmpty), .mmuOn(cfgMmuOn),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .l1IsTable(l1IsTable), .pop(qPop), .memReqValid(memReqValid), .strb(strb));

  ptw_dpath #(.ASID_W(ASID_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldVa(qHead[ENTRY_W-1 -: VA_W]), .ldFetch(qHead[ASID_W+1]),
    .ldWrite(qHead[ASID_W]), .ldAsid(qHead[ASID_W-1:0]),
    .cfgBase0(cfgBase0), .cfgBase1(cfgBase1), .cfgSplit(cfgSplit),
    .cfgCacheOn(cfgCacheOn), .cfgAfEn(cfgAfEn), .rspData(memRspData),
    .l1IsTable(l1IsTable), .memAddr(memReqAddr), .memUncached(memReqUncached),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillShift(fillShift), .fillAp(fillAp), .fillDomain(fillDomain),
    .fillGlobal(fillGlobal), .fillXn(fillXn), .fillAsid(fillAsid),
    .fillAttr(fillAttr), .faultValid(faultValid), .faultCode(faultCode),
    .faultFetch(faultFetch), .faultWrite(faultWrite));

  // R7: a pending descriptor read keeps its address until accepted
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 0, reqFetch = 0, reqWrite = 0, reqReady;
  logic [31:0] reqVa = 0;
  logic [7:0]  reqAsid = 0;
  logic [31:0] cfgBase0 = 32'h1234_7000, cfgBase1 = 32'h8000_0000;
  logic [2:0]  cfgSplit = 0;
  logic        cfgMmuOn = 1, cfgCacheOn = 1, cfgAfEn = 0;
  logic        memReqValid, memReqUncached, memRspValid = 0;
  logic        memReqReady = 1;
  logic [31:0] memReqAddr, memRspData = 0;
  logic        fillValid, fillGlobal, fillXn, faultValid, faultFetch, faultWrite;
  logic [19:0] fillVpn, fillPfn;
  logic [4:0]  fillShift;
  logic [2:0]  fillAp, faultCode;
  logic [3:0]  fillDomain;
  logic [7:0]  fillAsid;
  logic [10:0] fillAttr;

  ptw_walker #(.QUEUE_DEPTH(2), .ASID_W(8)) u0 (.*);

  int nChecks = 0, nFails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Memory responder: one-cycle latency, logs read addresses
  logic [31:0] curD1 = 0, curD2 = 0;
  logic [31:0] rdAddr [4];
  logic        rdUnc [4];
  int          rdCnt = 0;
  bit          rspDue = 0;
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspDue) begin
      memRspValid = 1'b1;
      memRspData  = (rdCnt == 1) ? curD1 : curD2;
      rspDue = 0;
    end
    if (memReqValid && rstN) begin
      if (rdCnt < 4) begin
        rdAddr[rdCnt] = memReqAddr;
        rdUnc[rdCnt]  = memReqUncached;
      end
      rdCnt++;
      rspDue = 1;
    end
  end

  typedef struct packed {
    logic [31:0] va; logic fetch; logic write; logic [2:0] split;
    logic cacheOn; logic afEn; logic [31:0] d1; logic [31:0] d2;
    logic [31:0] l1Addr; logic [31:0] l2Addr; logic [1:0] nRd;
    logic isFault; logic [2:0] code; logic [4:0] shift;
    logic [19:0] pfn; logic [19:0] vpn; logic [3:0] dom; logic [2:0] ap;
    logic glb; logic xn; logic [10:0] attr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R1 R3 R9: section via base 0, texcb 3
    '{32'h1230_0000,1'b0,1'b0,3'd0,1'b1,1'b0,32'hABC1_0CBE,32'h0,32'h1234_448C,32'h0,2'd1,
      1'b0,3'd0,5'd20,20'h00ABC,20'h00123,4'd5,3'd3,1'b1,1'b1,11'h4FC},
    // R1 R2 R7: base 1 chosen, fault type on fetch, uncached read
    '{32'h4560_0000,1'b1,1'b0,3'd2,1'b0,1'b0,32'h0,32'h0,32'h8000_1158,32'h0,2'd1,
      1'b1,3'd1,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R1 R2: base 0 with split 2, reserved type on write
    '{32'h3FF0_0000,1'b0,1'b1,3'd2,1'b1,1'b0,32'h3,32'h0,32'h1234_7FFC,32'h0,2'd1,
      1'b1,3'd1,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R4 R5 R7 R9: small page, texcb 4
    '{32'h0040_5000,1'b0,1'b0,3'd0,1'b0,1'b0,32'h0007_7D21,32'h5566_7A53,32'h1234_4010,32'h0007_7C14,2'd2,
      1'b0,3'd0,5'd12,20'h55667,20'h00405,4'd9,3'd5,1'b0,1'b1,11'h400},
    // R4 R5 R9: large page, texcb 18
    '{32'h0080_A000,1'b0,1'b1,3'd0,1'b1,1'b0,32'h0001_0001,32'h9ABC_4439,32'h1234_4020,32'h0001_0028,2'd2,
      1'b0,3'd0,5'd16,20'h09ABC,20'h00080,4'd0,3'd3,1'b1,1'b0,11'h4A0},
    // R5: invalid second level
    '{32'h0100_0000,1'b0,1'b0,3'd0,1'b1,1'b0,32'h0002_0061,32'h0,32'h1234_4040,32'h0002_0000,2'd2,
      1'b1,3'd2,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R6: access flag on section
    '{32'h0200_0000,1'b0,1'b1,3'd0,1'b1,1'b1,32'h0020_0802,32'h0,32'h1234_4080,32'h0,2'd1,
      1'b1,3'd3,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R6: access flag on small page
    '{32'h0300_0000,1'b1,1'b0,3'd0,1'b1,1'b1,32'h0003_0001,32'h1111_1022,32'h1234_40C0,32'h0003_0000,2'd2,
      1'b1,3'd4,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R10: supersection reported as translation fault
    '{32'h0400_0000,1'b0,1'b0,3'd0,1'b1,1'b0,32'h0004_0002,32'h0,32'h1234_4100,32'h0,2'd1,
      1'b1,3'd1,5'd0,20'h0,20'h0,4'd0,3'd0,1'b0,1'b0,11'h0},
    // R3 R9: not-global section, texcb 8, flag check passes
    '{32'h7FF0_0000,1'b0,1'b0,3'd0,1'b1,1'b1,32'h0013_2402,32'h0,32'h1234_5FFC,32'h0,2'd1,
      1'b0,3'd0,5'd20,20'h00001,20'h007FF,4'd0,3'd1,1'b0,1'b0,11'h430}
  };

  task automatic pushReq(input logic [31:0] va, input logic f, input logic w, input logic [7:0] a);
    @(negedge clk);
    reqVa = va; reqFetch = f; reqWrite = w; reqAsid = a; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitResult(output bit got);
    got = 0;
    for (int c = 0; c < 40 && !got; c++) begin
      if (fillValid || faultValid) got = 1;
      else @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    // Reset state (R12, R8)
    chk(!fillValid && !faultValid, "R12 reset outputs", {fillValid, faultValid}, 0);
    chk(!memReqValid, "R7 reset no read", memReqValid, 0);
    rstN = 1;
    @(negedge clk);
    chk(reqReady, "R8 ready after reset", reqReady, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cfgSplit = v.split; cfgCacheOn = v.cacheOn; cfgAfEn = v.afEn;
      curD1 = v.d1; curD2 = v.d2; rdCnt = 0;
      pushReq(v.va, v.fetch, v.write, 8'(i + 3));
      waitResult(got);
      chk(got, $sformatf("R12 v%0d outcome", i), got, 1);
      chk(rdCnt == int'(v.nRd), $sformatf("R4 v%0d reads", i), rdCnt, v.nRd);
      chk(rdAddr[0] == v.l1Addr, $sformatf("R1 v%0d L1 address", i), rdAddr[0], v.l1Addr);
      chk(rdUnc[0] == !v.cacheOn, $sformatf("R7 v%0d L1 uncached", i), rdUnc[0], !v.cacheOn);
      if (v.nRd == 2) begin
        chk(rdAddr[1] == v.l2Addr, $sformatf("R4 v%0d L2 address", i), rdAddr[1], v.l2Addr);
        chk(rdUnc[1] == 0, $sformatf("R7 v%0d L2 cached", i), rdUnc[1], 0);
      end
      chk(faultValid == v.isFault && fillValid == !v.isFault,
          $sformatf("R12 v%0d kind", i), {fillValid, faultValid}, {!v.isFault, v.isFault});
      if (v.isFault) begin
        chk(faultCode == v.code, $sformatf("R2 R5 R6 R10 v%0d code", i), faultCode, v.code);
        chk(faultFetch == v.fetch && faultWrite == v.write,
            $sformatf("R2 v%0d flags", i), {faultFetch, faultWrite}, {v.fetch, v.write});
      end else begin
        chk(fillShift == v.shift, $sformatf("R3 R5 v%0d shift", i), fillShift, v.shift);
        chk(fillPfn == v.pfn, $sformatf("R3 R5 v%0d pfn", i), fillPfn, v.pfn);
        chk(fillVpn == v.vpn, $sformatf("R3 v%0d vpn", i), fillVpn, v.vpn);
        chk(fillDomain == v.dom, $sformatf("R5 v%0d domain", i), fillDomain, v.dom);
        chk(fillAp == v.ap, $sformatf("R3 v%0d ap", i), fillAp, v.ap);
        chk(fillGlobal == v.glb && fillXn == v.xn, $sformatf("R3 v%0d global/xn", i),
            {fillGlobal, fillXn}, {v.glb, v.xn});
        chk(fillAsid == 8'(i + 3), $sformatf("R3 v%0d asid", i), fillAsid, i + 3);
        chk(fillAttr == v.attr, $sformatf("R9 v%0d attr", i), fillAttr, v.attr);
      end
      @(negedge clk);
      chk(!fillValid && !faultValid, $sformatf("R12 v%0d pulse", i), {fillValid, faultValid}, 0);
      repeat (2) @(negedge clk);
    end

    // R11 and R8: park two requests with translation off, then drain in order
    cfgMmuOn = 0; cfgSplit = 0; cfgAfEn = 0; cfgCacheOn = 1;
    curD1 = 32'h0AA0_0C02; curD2 = 32'h0BB0_0C02; rdCnt = 0;
    pushReq(32'h0500_0000, 0, 0, 8'h41);
    pushReq(32'h0600_0000, 0, 0, 8'h42);
    chk(!reqReady, "R8 full queue drops ready", reqReady, 0);
    repeat (6) @(negedge clk);
    chk(rdCnt == 0, "R11 no read while MMU off", rdCnt, 0);
    cfgMmuOn = 1;
    waitResult(got);
    chk(got && fillValid && fillVpn == 20'h050, "R8 first queued walk", fillVpn, 20'h050);
    chk(fillPfn == 20'h000AA, "R8 first pfn", fillPfn, 20'h000AA);
    @(negedge clk);
    waitResult(got);
    chk(got && fillValid && fillVpn == 20'h060, "R8 second queued walk", fillVpn, 20'h060);
    chk(fillAsid == 8'h42, "R8 second asid", fillAsid, 8'h42);
    chk(rdAddr[0] == 32'h1234_4140 && rdAddr[1] == 32'h1234_4180, "R8 read order",
        rdAddr[1], 32'h1234_4180);
    chk(reqReady, "R8 ready after drain", reqReady, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule